// File: doc/BRIEF.md
# Bridge Secondary-Side Error Status Register

This block holds the 16-bit status word that describes error events seen on the downstream (secondary) bus of a hub-to-PCI bridge. Bus protocol logic elsewhere raises one-cycle event strobes. The block captures each event in a sticky bit that stays set until software clears it by writing a one to that bit position. The remaining bit positions are constants that report fixed capabilities of the bridge.

The data-parity bit has two ways to be set. The first is a PERR# observed on a write while parity error response is enabled and an internal function owns the bus. The second is a parity error found internally on a read. A target abort on a cycle that needs a completion also produces a one-cycle request toward the primary-side status logic. The register port is a plain single-cycle write strobe with two byte enables. The read value is presented continuously.

Top module: `bridge_sec_status`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` equals 0x0280.
- R2: An `ev_bus_parity` strobe sets bit 15, which then stays 1 with no further events.
- R3: An `ev_serr_rcvd` strobe sets bit 14, and an `ev_master_abort` strobe sets bit 13.
- R4: An `ev_target_abort` strobe sets bit 12, whether or not `cmpl_required` is high.
- R5: Bit 8 sets on an `ev_perr_seen` strobe only when `perr_resp_en`, `master_internal` and `cycle_is_write` are all 1 in that cycle. If any one of them is 0, bit 8 is left unchanged.
- R6: An `ev_int_read_perr` strobe sets bit 8, and no qualifier is needed.
- R7: A write (`wr_en` = 1) with `wr_be[1]` = 1 clears each of bits 15, 14, 13, 12 and 8 whose `wr_data` bit is 1. Bits written with 0 keep their value. `wr_be[1]` covers bits 15:8 and `wr_be[0]` covers bits 7:0. A write with `wr_be[1]` = 0 clears nothing.
- R8: When a set event and a write-one clear reach the same bit in the same cycle, the bit ends up 1.
- R9: Bit 11 always reads 0, bits 10:9 read 01, bit 7 reads 1, and bits 6:0 read 0, regardless of any write.
- R10: `pri_tabort_req` is 1 in exactly the cycles where `ev_target_abort` and `cmpl_required` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_bus_parity | input | 1 | Parity error detected on the bus (strobe) |
| ev_serr_rcvd | input | 1 | SERR# received (strobe) |
| ev_master_abort | input | 1 | Downstream cycle master-aborted (strobe) |
| ev_target_abort | input | 1 | Downstream cycle target-aborted (strobe) |
| ev_perr_seen | input | 1 | PERR# observed (strobe) |
| ev_int_read_perr | input | 1 | Internal parity error on a read (strobe) |
| master_internal | input | 1 | Current bus master is an internal function |
| cycle_is_write | input | 1 | Current cycle is a write |
| perr_resp_en | input | 1 | Parity error response enable |
| cmpl_required | input | 1 | Current cycle requires a completion |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables for the write |
| wr_data | input | 16 | Write data (1 = clear) |
| rd_data | output | 16 | Current register value |
| pri_tabort_req | output | 1 | Request to set the primary-side signaled target abort |

## Verification
The hardest case to reach is a collision, where an event strobe and a write-one clear land on the same sticky bit in the same cycle. Reaching it needs the bit already set, the high byte enabled and the right data bit at one. A second hard case is the qualified PERR# path, which needs four inputs high together. Uniform random inputs rarely produce either case. The bench therefore drives directed collisions and sweeps every qualifier combination for the data-parity bit. It follows these with a random phase that biases strobes and writes toward high densities, so that same-cycle set and clear occur often. A cycle model in the bench checks every cycle of that phase.

// File: rtl/ssr_pkg.sv
// Package: shared constants for the bridge secondary status register.
// Bit positions are fixed because software decodes them.
package ssr_pkg;
    localparam int REG_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int NBYTES   = REG_W / BYTE_W;
    localparam int BIT_PAR  = 15;
    localparam int BIT_SERR = 14;
    localparam int BIT_MABT = 13;
    localparam int BIT_TABT = 12;
    localparam int BIT_DPAR = 8;
    localparam logic [REG_W-1:0] STICKY_MASK = (REG_W'(1) << BIT_PAR)  |
                                               (REG_W'(1) << BIT_SERR) |
                                               (REG_W'(1) << BIT_MABT) |
                                               (REG_W'(1) << BIT_TABT) |
                                               (REG_W'(1) << BIT_DPAR);
    // Constant capability bits: medium select timing (10:9 = 01), fast back-to-back (7).
    localparam logic [REG_W-1:0] FIXED_VAL = 16'h0280;
endpackage

// File: rtl/ssr_event_qual.sv
// Module: ssr_event_qual
// Turns the raw event strobes into a per-bit set vector for the sticky bank.
// It also produces the primary-side target-abort request.
// Assumes each strobe is high for one cycle per event. Purely combinational.
module ssr_event_qual
    import ssr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_bus_parity,
    input  logic             ev_serr_rcvd,
    input  logic             ev_master_abort,
    input  logic             ev_target_abort,
    input  logic             ev_perr_seen,
    input  logic             ev_int_read_perr,
    input  logic             master_internal,
    input  logic             cycle_is_write,
    input  logic             perr_resp_en,
    input  logic             cmpl_required,
    output logic [REG_W-1:0] set_vec,
    output logic             pri_req
);
    logic write_perr_hit;

    // Qualified write-side PERR# condition for the data-parity bit.
    always_comb begin
        write_perr_hit = ev_perr_seen & perr_resp_en & master_internal & cycle_is_write;
    end

    // Map each event to its bit position.
    always_comb begin
        set_vec           = '0;
        set_vec[BIT_PAR]  = ev_bus_parity;
        set_vec[BIT_SERR] = ev_serr_rcvd;
        set_vec[BIT_MABT] = ev_master_abort;
        set_vec[BIT_TABT] = ev_target_abort;
        set_vec[BIT_DPAR] = write_perr_hit | ev_int_read_perr;
    end

    // Completion-required target abort raises the upstream request in the same cycle.
    always_comb begin
        pri_req = ev_target_abort & cmpl_required;
    end

    // R10
    pri_req_needs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pri_req |-> (ev_target_abort && cmpl_required));

    // R5
    dpar_set_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[BIT_DPAR] |-> (ev_int_read_perr || ev_perr_seen));
endmodule

// File: rtl/ssr_sticky_bank.sv
// Module: ssr_sticky_bank
// A row of write-one-to-clear flops, one for each position set in MASK. Positions
// outside MASK are constant 0. Byte enables gate the clear by byte lane.
// A set in the same cycle as a clear wins, so no event is lost.
module ssr_sticky_bank #(
    parameter int               W     = 16,
    parameter int               LANE  = 8,
    parameter logic [W-1:0]     MASK  = '0,
    localparam int              LANES = W / LANE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     set_vec,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_be,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     q
);
    logic [W-1:0] clr_vec;

    // Expand byte enables to a per-bit clear vector.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        always_comb begin
            clr_vec[b*LANE +: LANE] = wr_data[b*LANE +: LANE] & {LANE{wr_en & wr_be[b]}};
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_sticky
            // Hold, clear on write-one, set on event with priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)          q[i] <= 1'b0;
                else if (set_vec[i]) q[i] <= 1'b1;
                else if (clr_vec[i]) q[i] <= 1'b0;
            end

            // R8
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> q[i]);

            // R7
            clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[i] && !set_vec[i]) |=> !q[i]);

            // R2
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_vec[i] && !set_vec[i]) |=> $stable(q[i]));
        end else begin : g_const
            always_comb q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/bridge_sec_status.sv
// Module: bridge_sec_status
// Secondary-side status register of a hub-to-PCI bridge. It joins the event
// qualifier, the sticky bank and the constant capability bits into one read value.
// Assumes strobes last one cycle and the write port is a single-cycle strobe.
module bridge_sec_status
    import ssr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_bus_parity,
    input  logic              ev_serr_rcvd,
    input  logic              ev_master_abort,
    input  logic              ev_target_abort,
    input  logic              ev_perr_seen,
    input  logic              ev_int_read_perr,
    input  logic              master_internal,
    input  logic              cycle_is_write,
    input  logic              perr_resp_en,
    input  logic              cmpl_required,
    input  logic              wr_en,
    input  logic [NBYTES-1:0] wr_be,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              pri_tabort_req
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] sticky_q;

    ssr_event_qual u_qual (
        .clk              (clk),
        .rst_n            (rst_n),
        .ev_bus_parity    (ev_bus_parity),
        .ev_serr_rcvd     (ev_serr_rcvd),
        .ev_master_abort  (ev_master_abort),
        .ev_target_abort  (ev_target_abort),
        .ev_perr_seen     (ev_perr_seen),
        .ev_int_read_perr (ev_int_read_perr),
        .master_internal  (master_internal),
        .cycle_is_write   (cycle_is_write),
        .perr_resp_en     (perr_resp_en),
        .cmpl_required    (cmpl_required),
        .set_vec          (set_vec),
        .pri_req          (pri_tabort_req)
    );

    ssr_sticky_bank #(
        .W    (REG_W),
        .LANE (BYTE_W),
        .MASK (STICKY_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .q       (sticky_q)
    );

    // Merge the sticky bits with the constant capability field.
    always_comb begin
        rd_data = sticky_q | FIXED_VAL;
    end

    // R10
    pri_req_marks_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pri_tabort_req |=> rd_data[BIT_TABT]);

    // R4
    tabort_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[BIT_TABT]) |-> $past(ev_target_abort));
endmodule

// File: tb/bridge_sec_status_test.sv
module bridge_sec_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_bus_parity = 0, ev_serr_rcvd = 0, ev_master_abort = 0, ev_target_abort = 0;
    logic        ev_perr_seen = 0, ev_int_read_perr = 0;
    logic        master_internal = 0, cycle_is_write = 0, perr_resp_en = 0, cmpl_required = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_be = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic        pri_tabort_req;

    int checks = 0;
    int errors = 0;
    logic [15:0] model = 16'h0280;

    always #10 clk = ~clk;

    bridge_sec_status uut (.*);

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [15:0] next_model(logic [15:0] cur);
        logic [15:0] s, c, n;
        s = '0;
        s[15] = ev_bus_parity;
        s[14] = ev_serr_rcvd;
        s[13] = ev_master_abort;
        s[12] = ev_target_abort;
        s[8]  = ev_int_read_perr | (ev_perr_seen & perr_resp_en & master_internal & cycle_is_write);
        c = (wr_en && wr_be[1]) ? (wr_data & 16'hF100) : 16'h0000;
        n = ((cur & ~c) | s) & 16'hF100;
        return n | 16'h0280;
    endfunction

    function automatic string req_of(logic [15:0] diff);
        if (diff & 16'h06FF) return "R9";
        if (diff[15]) return "R2";
        if (diff[14] || diff[13]) return "R3";
        if (diff[12]) return "R4";
        return "R5/R6";
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        {ev_bus_parity, ev_serr_rcvd, ev_master_abort, ev_target_abort} = '0;
        {ev_perr_seen, ev_int_read_perr, master_internal, cycle_is_write} = '0;
        {perr_resp_en, cmpl_required, wr_en} = '0;
        wr_be = '0;
        wr_data = '0;
    endtask

    // One cycle: inputs are already set at a negedge. Check the pulse, clock, check the register.
    task automatic step(string tag);
        #1;
        chk("R10", {15'd0, pri_tabort_req}, {15'd0, ev_target_abort & cmpl_required});
        model = next_model(model);
        @(negedge clk);
        chk(tag == "" ? req_of(rd_data ^ model) : tag, rd_data, model);
        idle();
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", rd_data, 16'h0280);

        // R2 set then hold
        ev_bus_parity = 1; step("R2");
        step("R2");
        // R3
        ev_serr_rcvd = 1; step("R3");
        ev_master_abort = 1; step("R3");
        // R4 / R10 with and without completion required
        ev_target_abort = 1; cmpl_required = 0; step("R4");
        wr_en = 1; wr_be = 2'b10; wr_data = 16'h1000; step("R7");
        ev_target_abort = 1; cmpl_required = 1; step("R4");
        // R7 clear with be[1]=0 has no effect
        wr_en = 1; wr_be = 2'b01; wr_data = 16'hFFFF; step("R7");
        // R7 writing zeros keeps bits
        wr_en = 1; wr_be = 2'b11; wr_data = 16'h0000; step("R7");
        // R7 clear all
        wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF; step("R7");
        chk("R9", rd_data, 16'h0280);
        // R5 sweep qualifiers
        for (int k = 0; k < 8; k++) begin
            ev_perr_seen = 1;
            {perr_resp_en, master_internal, cycle_is_write} = 3'(k);
            step("R5");
            wr_en = 1; wr_be = 2'b10; wr_data = 16'h0100; step("R7");
        end
        // R6
        ev_int_read_perr = 1; step("R6");
        // R8 collisions on each sticky bit
        ev_bus_parity = 1; ev_serr_rcvd = 1; ev_master_abort = 1; ev_target_abort = 1;
        ev_int_read_perr = 1; wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF; step("R8");
        // R9 writing zeros everywhere leaves fixed bits
        wr_en = 1; wr_be = 2'b11; wr_data = 16'h0000; step("R9");

        // Random phase with a fixed seed, dense strobes and writes.
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 3000; n++) begin
            ev_bus_parity    = ($urandom % 4) == 0;
            ev_serr_rcvd     = ($urandom % 4) == 0;
            ev_master_abort  = ($urandom % 4) == 0;
            ev_target_abort  = ($urandom % 3) == 0;
            ev_perr_seen     = ($urandom % 3) == 0;
            ev_int_read_perr = ($urandom % 6) == 0;
            master_internal  = $urandom % 2;
            cycle_is_write   = $urandom % 2;
            perr_resp_en     = $urandom % 2;
            cmpl_required    = $urandom % 2;
            wr_en            = ($urandom % 2) == 0;
            wr_be            = 2'($urandom);
            wr_data          = 16'($urandom);
            step("");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule